// File: doc/BRIEF.md
# JTAG user-register SPI bridge

This block hangs off a user-defined JTAG data register and converts a single data-register scan into a single chip-select-framed transaction with a serial flash. The host scans a frame that describes itself. Any number of zeros may come first. A one bit marks the start. A 32-bit cycle count follows, most significant bit first. The remaining bits are the payload: first the bits to send, then enough filler to cover the read latency and the receive window. The bridge parses this frame while it shifts. It drops chip select for exactly the counted number of serial clocks, forwards each payload bit to MOSI, and returns MISO on TDO with a fixed skew, so the host can discard the first returned bits.

The serial clock comes from TCK through logic, and no boundary-scan pin is involved. MOSI is updated on the falling edge of TCK, and the serial clock is high during the high phase of TCK. Both the flash and the bridge therefore sample on the rising edge of TCK. Leaving Shift-DR, an Update-DR, loss of select or a reset ends the transaction at once. The parser then waits for a new marker.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While rst_n is low at a rising and a falling TCK edge, the outputs settle to spi_cs_n=1, spi_sck=0, spi_mosi=0 and tdo=0.
- R2: While sel and shift are high, zero bits before the first one bit are ignored. That first one bit is the marker. The next 32 bits form the count N, most significant bit first. spi_cs_n stays 1 throughout the marker and the count field, whatever the number of leading zeros.
- R3: Number the scan steps from 0, and let P be the step after the last count bit. spi_cs_n, sampled just after each rising TCK edge, is 1 for steps below P, 0 for steps P to P+N, and 1 again at step P+N+1.
- R4: Exactly N serial clock pulses are issued. When N is 0, no pulse is issued and spi_cs_n never goes low.
- R5: Payload bit k, shifted at step P+k, is presented on spi_mosi from the next falling TCK edge. The flash samples it on rising serial clock edge k. Bytes therefore arrive with their first-shifted bit as the most significant bit.
- R6: tdo carries spi_miso as sampled at each rising TCK edge. The level that the flash presents for serial clock edge k appears on tdo after the rising edge of step P+k+1. This skew of one step does not change.
- R7: A payload of 0x9F followed by 24 clock-out bits, with N=32, returns the flash's 3-byte identification on tdo at steps P+9 to P+32, most significant bit first.
- R8: If shift falls, sel falls, update rises or rst_n falls during a transaction, spi_cs_n goes to 1 and spi_sck goes to 0 at once, without waiting for an edge. The parser then looks for a new marker, and the next frame works normally.
- R9: Once N payload bits have been consumed, further scan bits are ignored, including one bits. No serial clock pulse is issued, and spi_cs_n stays 1 until the scan ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | JTAG test clock; clocks all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | User data register selected by the instruction register |
| capture | input | 1 | TAP is in Capture-DR |
| shift | input | 1 | TAP is in Shift-DR |
| update | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Scan data in |
| tdo | output | 1 | Scan data out, carries sampled MISO |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Flash serial clock, derived from TCK |
| spi_mosi | output | 1 | Flash serial data in |
| spi_miso | input | 1 | Flash serial data out |

## Verification
The bench drives each scan bit 1 ns after a falling TCK edge. It records tdo and spi_cs_n 1 ns after the following rising edge, so every result is read in the step it is due. spi_cs_n changes between steps P-1 and P, and again between steps P+N and P+N+1. An identification bit j must appear at step P+9+j: 8 command clocks plus the one-step read skew. Abort checks are made half a nanosecond after shift or rst_n is dropped in the middle of a TCK high phase, which confirms that chip select and the serial clock fall without waiting for an edge. A behavioural flash in the bench counts serial clock pulses and records the command byte. This gives the pulse count and the MOSI bit order independently of the design.

// File: rtl/jsb_pkg.sv
// Shared types for the JTAG user-register SPI bridge.
package jsb_pkg;
    // Frame parser phases, in the order a frame passes through them.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,   // waiting for the marker bit
        ST_COUNT = 2'd1,   // loading the cycle count
        ST_XFER  = 2'd2,   // payload bits become serial clocks
        ST_DONE  = 2'd3    // count exhausted, rest of scan ignored
    } jsb_state_e;
endpackage

// File: rtl/jsb_frame_parser.sv
// Frame parser, rising-TCK domain.
// Tracks the marker, count and payload phases of one data-register scan.
// Assumes: 'active' is high only while the register is selected and
// shifting; any low cycle restarts the search for a marker.
module jsb_frame_parser
    import jsb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic        tck,
    input  logic        rst_n,
    input  logic        active,
    input  logic        tdi,
    output jsb_state_e  state,
    output logic        accept_q,
    output logic        tdi_q
);
    localparam int IDX_W = $clog2(CNT_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CNT_W - 1);

    logic [CNT_W-1:0] remain;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt_next;

    // Count register with the incoming bit shifted in.
    always_comb cnt_next = {remain[CNT_W-2:0], tdi};

    // Phase sequencing, count loading and payload bit acceptance.
    always_ff @(posedge tck) begin
        if (!rst_n || !active) begin
            state    <= ST_HUNT;
            remain   <= '0;
            idx      <= '0;
            accept_q <= 1'b0;
            tdi_q    <= 1'b0;
        end else begin
            accept_q <= 1'b0;
            case (state)
                ST_HUNT: begin
                    if (tdi) begin
                        state <= ST_COUNT;
                        idx   <= '0;
                    end
                end
                ST_COUNT: begin
                    remain <= cnt_next;
                    idx    <= idx + 1'b1;
                    if (idx == IDX_LAST)
                        state <= (cnt_next == '0) ? ST_DONE : ST_XFER;
                end
                ST_XFER: begin
                    accept_q <= 1'b1;
                    tdi_q    <= tdi;
                    remain   <= remain - CNT_W'(1);
                    if (remain == CNT_W'(1))
                        state <= ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // R4
    // xfer_cnt_nonzero_chk: the transfer phase never runs with nothing left
    xfer_cnt_nonzero_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_XFER) |-> (remain != '0));

    // R8
    // abort_hunt_chk: a cycle without shifting sends the parser back to marker search
    abort_hunt_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !active |=> (state == ST_HUNT));

    // R2
    // count_len_chk: the count field is exactly CNT_W bits long
    count_len_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (active && state == ST_COUNT && idx == IDX_LAST)
            |=> (state == ST_XFER || state == ST_DONE));
endmodule

// File: rtl/jsb_spi_phy.sv
// Flash pin driver.
// On the falling TCK edge it updates MOSI, the chip-select hold and the
// serial clock enable. On the rising edge it samples MISO for TDO.
// Assumes: 'active' drops as soon as the scan leaves the register;
// chip select and the serial clock are gated by it combinationally.
module jsb_spi_phy
    import jsb_pkg::*;
(
    input  logic        tck,
    input  logic        rst_n,
    input  logic        active,
    input  jsb_state_e  state,
    input  logic        accept_q,
    input  logic        tdi_q,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    output logic        tdo
);
    logic cs_act;
    logic sck_en;
    logic mosi_q;
    logic tdo_q;

    // Falling edge: launch MOSI and decide whether the next TCK high is a clock.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            cs_act <= 1'b0;
            sck_en <= 1'b0;
            mosi_q <= 1'b0;
        end else if (!active) begin
            cs_act <= 1'b0;
            sck_en <= 1'b0;
        end else begin
            cs_act <= (state == ST_XFER) || accept_q;
            sck_en <= accept_q;
            if (accept_q)
                mosi_q <= tdi_q;
        end
    end

    // Rising edge: sample the flash output, one step of fixed skew to TDO.
    always_ff @(posedge tck) begin
        if (!rst_n || !active)
            tdo_q <= 1'b0;
        else
            tdo_q <= spi_miso;
    end

    // Pin drive; chip select and clock fall at once on abort or reset.
    always_comb begin
        spi_cs_n = ~(cs_act & active & rst_n);
        spi_sck  = sck_en & tck & active & rst_n;
        spi_mosi = mosi_q;
        tdo      = tdo_q;
    end

    // R3
    // cs_idle_chk: chip select is never held while the parser is before the payload
    cs_idle_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_HUNT || state == ST_COUNT) |-> !cs_act);

    // R9
    // done_no_clock_chk: after the count is used up no new clock is enabled
    done_no_clock_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_DONE && !accept_q) |=> !sck_en);
endmodule

// File: rtl/jtag_spi_bridge.sv
// JTAG user-register SPI bridge, top level.
// Turns one data-register scan into one chip-select-framed flash
// transaction, by parsing a marker / count / payload frame as it shifts.
// Assumes: TAP state decode (sel, capture, shift, update) comes from an
// external controller and changes on rising TCK; reset is synchronous.
module jtag_spi_bridge
    import jsb_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic tck,
    input  logic rst_n,
    input  logic sel,
    input  logic capture,
    input  logic shift,
    input  logic update,
    input  logic tdi,
    output logic tdo,
    output logic spi_cs_n,
    output logic spi_sck,
    output logic spi_mosi,
    input  logic spi_miso
);
    logic       active;
    jsb_state_e state;
    logic       accept_q;
    logic       tdi_q;

    // Register is live only while selected and shifting.
    always_comb active = sel & shift & ~update & ~capture;

    jsb_frame_parser #(.CNT_W(CNT_W)) u_parser (
        .tck      (tck),
        .rst_n    (rst_n),
        .active   (active),
        .tdi      (tdi),
        .state    (state),
        .accept_q (accept_q),
        .tdi_q    (tdi_q)
    );

    jsb_spi_phy u_phy (
        .tck      (tck),
        .rst_n    (rst_n),
        .active   (active),
        .state    (state),
        .accept_q (accept_q),
        .tdi_q    (tdi_q),
        .spi_miso (spi_miso),
        .spi_cs_n (spi_cs_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .tdo      (tdo)
    );
endmodule

// File: tb/jtag_spi_bridge_tb.sv
// Directed bench for the JTAG user-register SPI bridge, with a
// behavioural flash that answers 0x9F with a fixed 3-byte identity.
module jtag_spi_bridge_tb;
    localparam logic [23:0] FLASH_ID = 24'h20BB19;

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
    logic tdo, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int checks = 0;
    int fails = 0;

    always #2.5 tck = ~tck;

    jtag_spi_bridge u_dut (
        .tck(tck), .rst_n(rst_n), .sel(sel), .capture(capture),
        .shift(shift), .update(update), .tdi(tdi), .tdo(tdo),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    // Behavioural flash: samples MOSI on rising SCK, drives MISO on falling SCK.
    int         fl_bc;
    logic [7:0] fl_cmd;
    logic [7:0] fl_got;
    logic       fl_miso;
    int         sck_pulses;

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            fl_bc  <= 0;
            fl_cmd <= 8'h00;
        end else begin
            if (fl_bc < 8) fl_cmd <= {fl_cmd[6:0], spi_mosi};
            if (fl_bc == 7) fl_got <= {fl_cmd[6:0], spi_mosi};
            fl_bc <= fl_bc + 1;
        end
    end

    always @(negedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n)
            fl_miso <= 1'b0;
        else if (fl_bc >= 8 && fl_bc < 32 && fl_cmd == 8'h9F)
            fl_miso <= FLASH_ID[31 - fl_bc];
        else
            fl_miso <= 1'b0;
    end

    assign spi_miso = fl_miso;

    always @(posedge spi_sck) sck_pulses = sck_pulses + 1;

    logic rx_rec [0:255];
    logic cs_rec [0:255];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One scan: lead zeros, marker, count, payload, pad; optional abort (1 shift, 2 reset).
    task automatic run_frame(input int lead, input logic [31:0] cnt,
                             input logic [63:0] payload, input int plen,
                             input int pad, input logic padbit,
                             input int abort_kind, input int abort_at);
        int p;
        int total;
        logic b;
        p = lead + 33;
        total = p + plen + pad;
        sck_pulses = 0;
        fl_got = 8'h00;
        for (int i = 0; i < total; i++) begin
            if (i < lead)               b = 1'b0;
            else if (i == lead)         b = 1'b1;
            else if (i < p)             b = cnt[31 - (i - lead - 1)];
            else if (i < p + plen)      b = payload[plen - 1 - (i - p)];
            else                        b = padbit;
            @(negedge tck); #1;
            sel = 1'b1; shift = 1'b1; tdi = b;
            @(posedge tck); #1;
            rx_rec[i] = tdo;
            cs_rec[i] = spi_cs_n;
            if (abort_kind != 0 && i == abort_at) begin
                if (abort_kind == 1) shift = 1'b0;
                else rst_n = 1'b0;
                #0.5;
                check(spi_cs_n == 1'b1, "R8 cs_n immediate", spi_cs_n, 1);
                check(spi_sck == 1'b0, "R8 sck immediate", spi_sck, 0);
                break;
            end
        end
        @(negedge tck); #1;
        shift = 1'b0; tdi = 1'b0;
        @(negedge tck); #1;
        update = 1'b1;
        @(negedge tck); #1;
        update = 1'b0; rst_n = 1'b1;
        repeat (2) @(negedge tck);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge tck);
        #1;
        check(spi_cs_n == 1'b1, "R1 cs_n", spi_cs_n, 1);
        check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
        check(spi_mosi == 1'b0, "R1 mosi", spi_mosi, 0);
        check(tdo == 1'b0, "R1 tdo", tdo, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge tck);
    endtask

    task automatic t_jedec(input int lead);
        int p;
        logic [23:0] id;
        bit cs_hi;
        p = lead + 33;
        run_frame(lead, 32, {32'h0, 8'h9F, 24'h0}, 32, 3, 1'b0, 0, 0);
        for (int j = 0; j < 24; j++) id[23 - j] = rx_rec[p + 9 + j];
        check(id == FLASH_ID, "R7 R6 identity on tdo", id, FLASH_ID);
        check(sck_pulses == 32, "R4 pulse count", sck_pulses, 32);
        check(fl_got == 8'h9F, "R5 command byte", fl_got, 8'h9F);
        cs_hi = 1'b1;
        for (int i = 0; i < p; i++) if (cs_rec[i] !== 1'b1) cs_hi = 1'b0;
        check(cs_hi, "R2 cs_n high through lead/marker/count", cs_hi, 1);
        check(cs_rec[p] == 1'b0, "R3 cs_n low at first payload step", cs_rec[p], 0);
        check(cs_rec[p + 32] == 1'b0, "R3 cs_n low at step P+N", cs_rec[p + 32], 0);
        check(cs_rec[p + 33] == 1'b1, "R3 cs_n high at step P+N+1", cs_rec[p + 33], 1);
    endtask

    task automatic t_short_pad_ones();
        int p;
        p = 33;
        run_frame(0, 8, {56'h0, 8'hA5}, 8, 6, 1'b1, 0, 0);
        check(sck_pulses == 8, "R4 R9 pulses with one-bit padding", sck_pulses, 8);
        check(fl_got == 8'hA5, "R5 MSB-first byte", fl_got, 8'hA5);
        check(cs_rec[p + 9] == 1'b1, "R9 cs_n stays high after count", cs_rec[p + 9], 1);
        check(cs_rec[p + 13] == 1'b1, "R9 cs_n high late in pad", cs_rec[p + 13], 1);
    endtask

    task automatic t_zero_count();
        bit cs_hi;
        run_frame(2, 0, {56'h0, 8'hFF}, 8, 2, 1'b1, 0, 0);
        check(sck_pulses == 0, "R4 zero count no pulses", sck_pulses, 0);
        cs_hi = 1'b1;
        for (int i = 0; i < 45; i++) if (cs_rec[i] !== 1'b1) cs_hi = 1'b0;
        check(cs_hi, "R4 zero count cs_n never low", cs_hi, 1);
    endtask

    task automatic t_abort(input int kind);
        run_frame(1, 32, {32'h0, 8'h9F, 24'h0}, 32, 3, 1'b0, kind, 34 + 10);
        check(spi_cs_n == 1'b1, "R8 cs_n high after abort", spi_cs_n, 1);
        t_jedec(0);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_jedec(0);
        t_jedec(5);
        t_short_pad_ones();
        t_zero_count();
        t_abort(1);
        t_abort(2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule